// File: doc/BRIEF.md
# Atomic Reservation Tracker

This block keeps the one reservation that a load-and-reserve / store-conditional instruction pair needs to build an atomic read-modify-write. A reserve-load records the 32-byte granule that holds its address. A later conditional store asks whether the reservation is still held. If it is, the store is released to memory as a single-beat write-through and the success flag is set. If it is not, nothing is written and the flag is cleared.

The reservation is lost when any conditional store executes, or when a snooped modify from another master touches any byte of the reserved granule. A snooped read that hits the granule only asks the cache to drop its copy of the block; the reservation survives it.

Success depends only on whether a reservation exists. The store address is not compared with the reserved address. All outputs are registered, so every effect appears one clock after the request.

Top module: `resv_unit`

## Requirements
- R1: After reset, and until the first reserve-load, resv_valid, eq_flag, wr_en, wr_single and blk_inv are all 0.
- R2: A reserve-load sets resv_valid to 1 one cycle later, with resv_granule equal to rsv_addr. rsv_addr is the address with its five offset bits (bits 4..0) removed. A later reserve-load replaces the granule, and a snooped modify to the old granule then has no effect.
- R3: A conditional store made while a live reservation exists produces, one cycle later, wr_en=1, wr_addr=sc_addr and eq_flag=1. This holds even when sc_addr lies outside the reserved granule.
- R4: A conditional store made with no reservation produces, one cycle later, wr_en=0 and eq_flag=0.
- R5: Every conditional store, whether it passes or fails, leaves resv_valid at 0 one cycle later, unless a reserve-load arrives in the same cycle.
- R6: A snooped modify whose granule equals resv_granule clears resv_valid one cycle later. A snooped modify to any other granule leaves the reservation unchanged.
- R7: A snooped read whose granule equals a valid resv_granule pulses blk_inv for one cycle and leaves resv_valid and resv_granule unchanged. With no valid reservation, blk_inv stays 0.
- R8: A reserve-load takes priority over a clear from a snooped modify, and over a clear from a conditional store, in the same cycle. The result is a valid reservation on the new granule.
- R9: A snooped modify that hits the reserved granule in the same cycle as a conditional store makes that store fail: wr_en=0 and eq_flag=0.
- R10: eq_flag keeps its value in every cycle without a conditional store.
- R11: Every write is a one-cycle pulse of wr_en, with wr_single=1 in the same cycle. Such a pulse appears only in the cycle after a conditional store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_req | input | 1 | Reserve-load request |
| rsv_addr | input | AW-5 | Granule index of the reserve-load address |
| sc_req | input | 1 | Conditional-store request |
| sc_addr | input | AW | Byte address of the conditional store |
| snp_mod | input | 1 | Snooped modify by another master |
| snp_rd | input | 1 | Snooped read by another master |
| snp_addr | input | AW-5 | Granule index of the snooped address |
| eq_flag | output | 1 | Success flag of the last conditional store |
| wr_en | output | 1 | Memory write request for a passing store |
| wr_single | output | 1 | Write is a single-beat write-through |
| wr_addr | output | AW | Address of the memory write |
| blk_inv | output | 1 | Snooped read hit the reserved block, so invalidate it |
| resv_valid | output | 1 | Reservation held |
| resv_granule | output | AW-5 | Reserved granule index |

## Verification
The assertions assume that each request is a single-cycle strobe and that a request's address is meaningful only in the cycle its strobe is high. The assertions that check retention also assume that no other request is active in the same cycle. The stimulus raises every strobe for exactly one cycle and drops it at the next falling edge. It combines strobes in one cycle only in the vectors that exercise R8 and R9, and the properties that need a quiet cycle exclude those combinations explicitly.

// File: rtl/resv_pkg.sv
package resv_pkg;
    localparam int DEF_AW         = 32;
    localparam int DEF_GRAN_BYTES = 32;

    typedef enum logic [1:0] {
        SC_NONE = 2'd0,
        SC_PASS = 2'd1,
        SC_FAIL = 2'd2
    } sc_res_e;
endpackage

// File: rtl/resv_granule_match.sv
module resv_granule_match #(
    parameter int GW = 27
) (
    input  logic          held,
    input  logic [GW-1:0] held_gran,
    input  logic [GW-1:0] probe_gran,
    output logic          hit
);
    always_comb begin
        hit = held && (held_gran == probe_gran);
    end
endmodule

// File: rtl/resv_sc_resolve.sv
module resv_sc_resolve
    import resv_pkg::*;
(
    input  logic    sc_req,
    input  logic    live,
    output sc_res_e result
);
    always_comb begin
        if (!sc_req)   result = SC_NONE;
        else if (live) result = SC_PASS;
        else           result = SC_FAIL;
    end
endmodule

// File: rtl/resv_unit.sv
module resv_unit
    import resv_pkg::*;
#(
    parameter int AW         = DEF_AW,
    parameter int GRAN_BYTES = DEF_GRAN_BYTES
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rsv_req,
    input  logic [AW-$clog2(GRAN_BYTES)-1:0] rsv_addr,
    input  logic                           sc_req,
    input  logic [AW-1:0]                  sc_addr,
    input  logic                           snp_mod,
    input  logic                           snp_rd,
    input  logic [AW-$clog2(GRAN_BYTES)-1:0] snp_addr,
    output logic                           eq_flag,
    output logic                           wr_en,
    output logic                           wr_single,
    output logic [AW-1:0]                  wr_addr,
    output logic                           blk_inv,
    output logic                           resv_valid,
    output logic [AW-$clog2(GRAN_BYTES)-1:0] resv_granule
);
    localparam int GB = $clog2(GRAN_BYTES);
    localparam int GW = AW - GB;

    typedef struct packed {
        logic          vld;
        logic [GW-1:0] gran;
        logic          eq;
        logic          wr_en;
        logic          wr_single;
        logic [AW-1:0] wr_addr;
        logic          blk_inv;
    } state_t;

    state_t  st_d, st_q;
    logic    snp_hit;
    logic    mod_hit_d;
    logic    rd_hit_d;
    logic    live_d;
    sc_res_e sc_res_d;

    // One granule comparator serves both snoop kinds.
    resv_granule_match #(.GW(GW)) u_snp_match (
        .held       (st_q.vld),
        .held_gran  (st_q.gran),
        .probe_gran (snp_addr),
        .hit        (snp_hit)
    );

    resv_sc_resolve u_sc_resolve (
        .sc_req (sc_req),
        .live   (live_d),
        .result (sc_res_d)
    );

    always_comb begin
        mod_hit_d = snp_mod && snp_hit;
        rd_hit_d  = snp_rd && snp_hit;
        // A modify hit in the same cycle as a store is ordered before it.
        live_d    = st_q.vld && !mod_hit_d;

        st_d           = st_q;
        st_d.wr_en     = 1'b0;
        st_d.wr_single = 1'b0;
        st_d.blk_inv   = rd_hit_d;

        unique case (sc_res_d)
            SC_PASS: begin
                st_d.wr_en     = 1'b1;
                st_d.wr_single = 1'b1;
                st_d.wr_addr   = sc_addr;
                st_d.eq        = 1'b1;
            end
            SC_FAIL: st_d.eq = 1'b0;
            default: ;
        endcase

        if (sc_req || mod_hit_d) begin
            st_d.vld = 1'b0;
        end
        // A reserve-load wins over every clear in the same cycle.
        if (rsv_req) begin
            st_d.vld  = 1'b1;
            st_d.gran = rsv_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eq_flag      = st_q.eq;
    assign wr_en        = st_q.wr_en;
    assign wr_single    = st_q.wr_single;
    assign wr_addr      = st_q.wr_addr;
    assign blk_inv      = st_q.blk_inv;
    assign resv_valid   = st_q.vld;
    assign resv_granule = st_q.gran;
endmodule

// File: rtl/resv_unit_chk.sv
module resv_unit_chk #(
    parameter int GW = 27
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rsv_req,
    input logic [GW-1:0] rsv_addr,
    input logic          sc_req,
    input logic          snp_mod,
    input logic          snp_rd,
    input logic          eq_flag,
    input logic          wr_en,
    input logic          wr_single,
    input logic          resv_valid,
    input logic [GW-1:0] resv_granule
);
    p_reserve_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_req |=> (resv_valid && resv_granule == $past(rsv_addr)));

    p_nothing_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(resv_valid));

    p_fail_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !resv_valid) |=> (!wr_en && !eq_flag));

    p_sc_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !rsv_req) |=> !resv_valid);

    p_read_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_rd && !snp_mod && !sc_req && !rsv_req && resv_valid)
        |=> (resv_valid && $stable(resv_granule)));

    p_eq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_req |=> $stable(eq_flag));

    p_write_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_single && $past(sc_req)));
endmodule

bind resv_unit resv_unit_chk #(.GW(GW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rsv_req      (rsv_req),
    .rsv_addr     (rsv_addr),
    .sc_req       (sc_req),
    .snp_mod      (snp_mod),
    .snp_rd       (snp_rd),
    .eq_flag      (eq_flag),
    .wr_en        (wr_en),
    .wr_single    (wr_single),
    .resv_valid   (resv_valid),
    .resv_granule (resv_granule)
);

// File: tb/resv_unit_tb.sv
module resv_unit_tb;
    localparam int AW = 32;
    localparam int GB = 5;
    localparam int GW = AW - GB;

    typedef struct packed {
        logic        rsv;
        logic        sc;
        logic        smod;
        logic        srd;
        logic [31:0] a_rsv;
        logic [31:0] a_sc;
        logic [31:0] a_snp;
        logic        x_vld;
        logic [31:0] x_gaddr;
        logic        x_eq;
        logic        x_wr;
        logic        x_inv;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        // R2 reserve
        '{1'b1,1'b0,1'b0,1'b0, 32'h1000_0040, 32'h0, 32'h0,          1'b1, 32'h1000_0040, 1'b0,1'b0,1'b0},
        // R3 R5 store outside granule still passes, clears
        '{1'b0,1'b1,1'b0,1'b0, 32'h0, 32'h2000_0004, 32'h0,          1'b0, 32'h0,         1'b1,1'b1,1'b0},
        // R4 store without reservation
        '{1'b0,1'b1,1'b0,1'b0, 32'h0, 32'h1000_0040, 32'h0,          1'b0, 32'h0,         1'b0,1'b0,1'b0},
        // R10 idle keeps eq
        '{1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0, 32'h0,                  1'b0, 32'h0,         1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0, 32'h1000_0040, 32'h0, 32'h0,          1'b1, 32'h1000_0040, 1'b0,1'b0,1'b0},
        // R7 snoop read hit
        '{1'b0,1'b0,1'b0,1'b1, 32'h0, 32'h0, 32'h1000_005C,          1'b1, 32'h1000_0040, 1'b0,1'b0,1'b1},
        // R6 modify just past the granule
        '{1'b0,1'b0,1'b1,1'b0, 32'h0, 32'h0, 32'h1000_0060,          1'b1, 32'h1000_0040, 1'b0,1'b0,1'b0},
        // R6 modify on last byte of granule
        '{1'b0,1'b0,1'b1,1'b0, 32'h0, 32'h0, 32'h1000_005F,          1'b0, 32'h0,         1'b0,1'b0,1'b0},
        // R4 store after snoop kill
        '{1'b0,1'b1,1'b0,1'b0, 32'h0, 32'h1000_0040, 32'h0,          1'b0, 32'h0,         1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0, 32'h3000_0000, 32'h0, 32'h0,          1'b1, 32'h3000_0000, 1'b0,1'b0,1'b0},
        // R2 replace
        '{1'b1,1'b0,1'b0,1'b0, 32'h3000_0100, 32'h0, 32'h0,          1'b1, 32'h3000_0100, 1'b0,1'b0,1'b0},
        // R2 modify to old granule ignored
        '{1'b0,1'b0,1'b1,1'b0, 32'h0, 32'h0, 32'h3000_0000,          1'b1, 32'h3000_0100, 1'b0,1'b0,1'b0},
        // R8 reserve beats snoop clear
        '{1'b1,1'b0,1'b1,1'b0, 32'h4000_0000, 32'h0, 32'h3000_0104,  1'b1, 32'h4000_0000, 1'b0,1'b0,1'b0},
        // R9 snoop kill with store same cycle
        '{1'b0,1'b1,1'b1,1'b0, 32'h0, 32'h4000_0008, 32'h4000_0010,  1'b0, 32'h0,         1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0, 32'h4000_0000, 32'h0, 32'h0,          1'b1, 32'h4000_0000, 1'b0,1'b0,1'b0},
        // R8 reserve beats store clear; store passes
        '{1'b1,1'b1,1'b0,1'b0, 32'h5000_0000, 32'h4000_000C, 32'h0,  1'b1, 32'h5000_0000, 1'b1,1'b1,1'b0},
        // R10 R11 idle: eq held, pulse gone
        '{1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0, 32'h0,                  1'b1, 32'h5000_0000, 1'b1,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,1'b0, 32'h0, 32'h0, 32'h5000_001F,          1'b0, 32'h0,         1'b1,1'b0,1'b0},
        // R7 read with no reservation
        '{1'b0,1'b0,1'b0,1'b1, 32'h0, 32'h0, 32'h5000_0000,          1'b0, 32'h0,         1'b1,1'b0,1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rsv_req, sc_req, snp_mod, snp_rd;
    logic [GW-1:0] rsv_addr, snp_addr;
    logic [AW-1:0] sc_addr;
    logic          eq_flag, wr_en, wr_single, blk_inv, resv_valid;
    logic [AW-1:0] wr_addr;
    logic [GW-1:0] resv_granule;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    resv_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .rsv_req(rsv_req), .rsv_addr(rsv_addr),
        .sc_req(sc_req), .sc_addr(sc_addr),
        .snp_mod(snp_mod), .snp_rd(snp_rd), .snp_addr(snp_addr),
        .eq_flag(eq_flag), .wr_en(wr_en), .wr_single(wr_single),
        .wr_addr(wr_addr), .blk_inv(blk_inv),
        .resv_valid(resv_valid), .resv_granule(resv_granule)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rsv_req = 1'b0; sc_req = 1'b0; snp_mod = 1'b0; snp_rd = 1'b0;
        rsv_addr = '0; sc_addr = '0; snp_addr = '0;
    endtask

    task automatic step(input vec_t v, input int idx);
        @(negedge clk);
        rsv_req  = v.rsv;  sc_req = v.sc; snp_mod = v.smod; snp_rd = v.srd;
        rsv_addr = v.a_rsv[31:GB];
        sc_addr  = v.a_sc;
        snp_addr = v.a_snp[31:GB];
        @(posedge clk);
        #1;
        chk($sformatf("R2/R5/R6 vec%0d resv_valid", idx), 32'(resv_valid), 32'(v.x_vld));
        if (v.x_vld)
            chk($sformatf("R2/R8 vec%0d resv_granule", idx), 32'(resv_granule), 32'(v.x_gaddr[31:GB]));
        chk($sformatf("R3/R4/R9/R10 vec%0d eq_flag", idx), 32'(eq_flag), 32'(v.x_eq));
        chk($sformatf("R3/R4/R11 vec%0d wr_en", idx), 32'(wr_en), 32'(v.x_wr));
        chk($sformatf("R11 vec%0d wr_single", idx), 32'(wr_single), 32'(v.x_wr));
        if (v.x_wr)
            chk($sformatf("R3 vec%0d wr_addr", idx), wr_addr, v.a_sc);
        chk($sformatf("R7 vec%0d blk_inv", idx), 32'(blk_inv), 32'(v.x_inv));
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 resv_valid", 32'(resv_valid), 32'd0);
        chk("R1 eq_flag", 32'(eq_flag), 32'd0);
        chk("R1 wr_en", 32'(wr_en), 32'd0);
        chk("R1 wr_single", 32'(wr_single), 32'd0);
        chk("R1 blk_inv", 32'(blk_inv), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(TBL[i], i);
        end
        @(negedge clk);
        idle_inputs();

        // R1: reset in mid-run drops a live reservation
        step('{1'b1,1'b0,1'b0,1'b0, 32'h6000_0000, 32'h0, 32'h0, 1'b1, 32'h6000_0000, 1'b1,1'b0,1'b0}, 100);
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 mid-run reset resv_valid", 32'(resv_valid), 32'd0);
        chk("R1 mid-run reset eq_flag", 32'(eq_flag), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 first store after reset fails
        step('{1'b0,1'b1,1'b0,1'b0, 32'h0, 32'h7000_0000, 32'h0, 1'b0, 32'h0, 1'b0,1'b0,1'b0}, 101);

        // R3 R11: store lands, one-cycle pulse only
        step('{1'b1,1'b0,1'b0,1'b0, 32'h7000_0020, 32'h0, 32'h0, 1'b1, 32'h7000_0020, 1'b0,1'b0,1'b0}, 102);
        step('{1'b0,1'b1,1'b0,1'b0, 32'h0, 32'h7000_003C, 32'h0, 1'b0, 32'h0, 1'b1,1'b1,1'b0}, 103);
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        #1;
        chk("R11 wr_en falls after one cycle", 32'(wr_en), 32'd0);
        chk("R10 eq_flag held", 32'(eq_flag), 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule